// File: doc/BRIEF.md
# PHY Management Serial Master

This block runs the two-wire management link to external Ethernet PHY chips. It generates the management clock (MDC) from the system clock and turns each command into a serial frame on the bidirectional data line (MDIO). A command names one of 32 PHYs, one of 32 registers inside it, the direction, and the 16-bit value for writes. The data line is brought out as three plain pins: a driven value, an output enable and the sampled input. The pad or the board provides the tri-state buffer and the pull-up.

Commands enter on a valid/ready handshake. `cmd_ready` is the inverse of `busy`, so an upstream source holding `cmd_valid` is stalled until the current frame has finished. A pulse offered while busy is lost and has no effect. Read results leave as a one-cycle `rd_valid` strobe with `rd_data`. This side has no back-pressure: the consumer must take the word in that cycle.

The MDC half-period is computed from the system clock period parameter. MDC stays low whenever no frame is in progress.

Top module: `mdio_master`

## Requirements
- R1: After reset, `mdc`, `busy`, `mdio_oe` and `rd_valid` are low and `cmd_ready` is high.
- R2: During a frame, every MDC high phase and every low phase inside the frame lasts exactly HALF_CYC = ceil(200 ns / SYS_PERIOD_NS) system clocks (at least 1). Each phase is therefore at least 160 ns and each MDC period at least 400 ns.
- R3: Whenever `busy` is low, `mdc` is low and `mdio_oe` is low.
- R4: A write frame sends one bit per MDC period, MSB first, with `mdio_oe` high on every bit. The bits are: PRE_LEN ones, start bits 01, opcode 01, the 5-bit PHY address, the 5-bit register address, turnaround 10, and the 16 data bits.
- R5: A read frame sends the same header with opcode 10. `mdio_oe` is high through the register address and low for the two turnaround bits and the 16 data bits.
- R6: On a read, `mdio_i` is sampled on the system clock edge at which `mdc` rises in each of the 16 data periods, and the first sample becomes bit 15. The word appears on `rd_data` with a one-cycle `rd_valid` in the cycle in which `busy` falls.
- R7: A command is accepted on a clock edge with `cmd_valid` and `cmd_ready` both high. `busy` is high from the next cycle for exactly 2·HALF_CYC·(PRE_LEN+32) cycles, and `cmd_ready` is its inverse.
- R8: `cmd_valid` while `busy` is high changes neither the frame in progress nor anything after it: no further frame is started.
- R9: `mdio_o` and `mdio_oe` change only while `mdc` is low. New bits are launched at the edge that drops `mdc` or at command acceptance, and they stay unchanged for the whole high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (not busy) |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_phy | input | 5 | Target PHY address |
| cmd_reg | input | 5 | Target register address |
| cmd_wdata | input | 16 | Value for a write |
| busy | output | 1 | Frame in progress |
| rd_valid | output | 1 | One-cycle strobe: read word available |
| rd_data | output | 16 | Last read word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| mdio_i | input | 1 | Sampled data line |

## Verification
The bench builds the block with SYS_PERIOD_NS = 20 and PRE_LEN = 32. That gives a 10-cycle half-period and a full 64-bit frame of 1280 cycles, so the real preamble length and the real 400 ns MDC period are both exercised. With these values the bench covers the address extremes 0 and 31 and data patterns with alternating, all-one, all-zero and edge-bit values. It also covers back-to-back commands issued in the very cycle that `busy` drops, and a command pulse held for several cycles in the middle of a read.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned ADDR_W    = 5;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned HDR_BITS  = 14;  // start + opcode + two addresses
  localparam int unsigned TA_BITS   = 2;
  localparam int unsigned BODY_BITS = HDR_BITS + TA_BITS + DATA_W;

  typedef enum logic [1:0] {
    OP_WR = 2'b01,
    OP_RD = 2'b10
  } mdio_op_e;

  localparam logic [1:0] SOF_BITS = 2'b01;
  localparam logic [1:0] TA_DRIVE = 2'b10;

  // Everything after the preamble, MSB first on the wire.
  function automatic logic [BODY_BITS-1:0] pack_body(
    input logic              rd,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] rga,
    input logic [DATA_W-1:0] wd
  );
    logic [1:0] opb;
    opb = rd ? OP_RD : OP_WR;
    return {SOF_BITS, opb, phy, rga,
            rd ? 2'b11 : TA_DRIVE,
            rd ? {DATA_W{1'b1}} : wd};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int unsigned HALF_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int unsigned CW = (HALF_CYC < 2) ? 1 : $clog2(HALF_CYC);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == CW'(HALF_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // Strobes mark the edge on which mdc is about to toggle.
  assign rise_stb = run && wrap && !mdc;
  assign fall_stb = run && wrap &&  mdc;
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq #(
  parameter int unsigned FRAME_BITS = 64,
  localparam int unsigned IW = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_rd,
  input  logic          fall_stb,
  output logic          busy,
  output logic          rd_mode,
  output logic [IW-1:0] bit_idx,
  output logic          end_stb,
  output logic          shift_stb
);
  logic last;

  assign last      = (bit_idx == IW'(FRAME_BITS - 1));
  assign end_stb   = busy && fall_stb &&  last;
  assign shift_stb = busy && fall_stb && !last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rd_mode <= 1'b0;
      bit_idx <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      rd_mode <= start_rd;
      bit_idx <= '0;
    end else if (end_stb) begin
      busy    <= 1'b0;
      bit_idx <= '0;
    end else if (shift_stb) begin
      bit_idx <= bit_idx + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_tx_shift.sv
module mdio_tx_shift
  import mdio_pkg::*;
#(
  parameter int unsigned PRE_LEN = 32,
  localparam int unsigned FB = PRE_LEN + BODY_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_rd,
  input  logic [ADDR_W-1:0] phy,
  input  logic [ADDR_W-1:0] rga,
  input  logic [DATA_W-1:0] wdata,
  input  logic              shift,
  output logic              mdio_o
);
  logic [FB-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr <= '1;
    end else if (load) begin
      sr <= {{PRE_LEN{1'b1}}, pack_body(load_rd, phy, rga, wdata)};
    end else if (shift) begin
      sr <= {sr[FB-2:0], 1'b1};
    end
  end

  assign mdio_o = sr[FB-1];
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture
  import mdio_pkg::*;
#(
  parameter int unsigned PRE_LEN = 32,
  localparam int unsigned FB = PRE_LEN + BODY_BITS,
  localparam int unsigned IW = $clog2(FB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_stb,
  input  logic              rd_mode,
  input  logic              busy,
  input  logic [IW-1:0]     bit_idx,
  input  logic              mdio_i,
  output logic [DATA_W-1:0] word
);
  localparam logic [IW-1:0] FIRST_DATA = IW'(PRE_LEN + HDR_BITS + TA_BITS);

  logic take;
  assign take = busy && rd_mode && rise_stb && (bit_idx >= FIRST_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word <= '0;
    end else if (take) begin
      word <= {word[DATA_W-2:0], mdio_i};
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned SYS_PERIOD_NS = 20,
  parameter int unsigned PRE_LEN       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_read,
  input  logic [ADDR_W-1:0] cmd_phy,
  input  logic [ADDR_W-1:0] cmd_reg,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  // Half of the 400 ns minimum period; also covers the 160 ns phase floor.
  localparam int unsigned HALF_NS    = 200;
  localparam int unsigned HALF_RAW   = (HALF_NS + SYS_PERIOD_NS - 1) / SYS_PERIOD_NS;
  localparam int unsigned HALF_CYC   = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam int unsigned FRAME_BITS = PRE_LEN + BODY_BITS;
  localparam int unsigned IW         = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] RD_RELEASE = IW'(PRE_LEN + HDR_BITS);

  logic          cmd_fire;
  logic          rise_stb, fall_stb;
  logic          rd_mode, end_stb, shift_stb;
  logic [IW-1:0] bit_idx;
  logic [DATA_W-1:0] cap_word;

  assign cmd_ready = !busy;
  assign cmd_fire  = cmd_valid && !busy;

  mdio_mdc_gen #(.HALF_CYC(HALF_CYC)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_seq #(.FRAME_BITS(FRAME_BITS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (cmd_fire),
    .start_rd  (cmd_read),
    .fall_stb  (fall_stb),
    .busy      (busy),
    .rd_mode   (rd_mode),
    .bit_idx   (bit_idx),
    .end_stb   (end_stb),
    .shift_stb (shift_stb)
  );

  mdio_tx_shift #(.PRE_LEN(PRE_LEN)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cmd_fire),
    .load_rd (cmd_read),
    .phy     (cmd_phy),
    .rga     (cmd_reg),
    .wdata   (cmd_wdata),
    .shift   (shift_stb),
    .mdio_o  (mdio_o)
  );

  mdio_rx_capture #(.PRE_LEN(PRE_LEN)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_stb (rise_stb),
    .rd_mode  (rd_mode),
    .busy     (busy),
    .bit_idx  (bit_idx),
    .mdio_i   (mdio_i),
    .word     (cap_word)
  );

  // Release the line for turnaround and data on reads.
  assign mdio_oe = busy && (!rd_mode || (bit_idx < RD_RELEASE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= end_stb && rd_mode;
      if (end_stb && rd_mode) rd_data <= cap_word;
    end
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int unsigned SYS_PERIOD_NS = 20,
  parameter int unsigned PRE_LEN       = 32
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic busy,
  input logic rd_valid,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe
);
  localparam int unsigned MIN_CYC = (160 + SYS_PERIOD_NS - 1) / SYS_PERIOD_NS;
  localparam int unsigned PRE_USED = PRE_LEN;

  logic        mdc_q;
  logic [15:0] len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdc_q <= 1'b0;
      len   <= '1;
    end else begin
      mdc_q <= mdc;
      if (mdc != mdc_q)  len <= 16'd1;
      else if (len != '1) len <= len + 1'b1;
    end
  end

  p_phase_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc != mdc_q) |-> (len >= 16'(MIN_CYC)));

  p_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);

  p_busy_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

  p_rd_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($fell(busy) && !$past(mdio_oe)));

  p_hold_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  initial begin
    p_pre_nonzero_r4: assert (PRE_USED > 0);
  end
endmodule

bind mdio_master mdio_master_chk #(
  .SYS_PERIOD_NS (SYS_PERIOD_NS),
  .PRE_LEN       (PRE_LEN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .busy      (busy),
  .rd_valid  (rd_valid),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int HALF   = 10;   // 200 ns / 20 ns
  localparam int FBITS  = 64;
  localparam int BUSY_C = 2 * HALF * FBITS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_read = 1'b0;
  logic [4:0] cmd_phy = '0, cmd_reg = '0;
  logic [15:0] cmd_wdata = '0;
  logic cmd_ready, busy, rd_valid, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic mdio_i = 1'b1;

  always #10 clk = ~clk;

  mdio_master #(.SYS_PERIOD_NS(20), .PRE_LEN(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_read(cmd_read), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
    .cmd_wdata(cmd_wdata), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_total = 0, n_bad = 0;
  logic [63:0] exp_bits[$];
  logic [63:0] exp_oe[$];
  logic [15:0] exp_rd[$];
  logic        cur_rd = 1'b0;
  logic [15:0] phy_resp = '0;

  function automatic void chk(input bit ok, input string req, input string what,
                              input logic [63:0] act, input logic [63:0] exp);
    n_total++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endfunction

  // Monitor / scoreboard
  logic prev_mdc = 1'b0, prev_o = 1'b1, prev_oe = 1'b0, prev_busy = 1'b0;
  logic [63:0] bits_got = '0, oe_got = '0;
  int nrise = 0, ph_len = 0, bcnt = 0, fr_count = 0;
  int min_hi = 1 << 30, max_hi = 0, min_lo = 1 << 30;
  bit hold_bad = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mdc != prev_mdc) begin
        if (prev_mdc) begin
          if (ph_len < min_hi) min_hi = ph_len;
          if (ph_len > max_hi) max_hi = ph_len;
        end else if (ph_len < min_lo) min_lo = ph_len;
        ph_len = 1;
        if (mdc) begin
          bits_got = {bits_got[62:0], mdio_o};
          oe_got   = {oe_got[62:0], mdio_oe};
          nrise++;
        end else if (cur_rd && nrise >= 48 && nrise < 64) begin
          mdio_i = phy_resp[15 - (nrise - 48)];
        end else begin
          mdio_i = 1'b1;
        end
      end else begin
        ph_len++;
      end
      if (mdc && prev_mdc && (mdio_o != prev_o || mdio_oe != prev_oe)) hold_bad = 1'b1;
      if (busy) bcnt++;
      if (prev_busy && !busy) begin
        fr_count++;
        if (exp_bits.size() == 0) begin
          chk(1'b0, "R8", "unexpected frame", bits_got, '0);
        end else begin
          logic [63:0] eb, eo;
          eb = exp_bits.pop_front();
          eo = exp_oe.pop_front();
          chk(nrise == FBITS, "R4", "bits per frame", 64'(nrise), 64'(FBITS));
          chk(oe_got == eo, "R5", "drive enable pattern", oe_got, eo);
          chk((bits_got & eo) == (eb & eo), "R4", "frame bits", bits_got & eo, eb & eo);
          chk(min_hi == HALF && max_hi == HALF && min_lo == HALF, "R2",
              "phase length", 64'(min_lo), 64'(HALF));
          chk(min_hi * 20 >= 160 && (min_hi + min_lo) * 20 >= 400, "R2",
              "ns limits", 64'(min_hi + min_lo), 64'(20));
          chk(!mdc && !mdio_oe, "R3", "idle lines", {mdc, mdio_oe}, '0);
          chk(bcnt == BUSY_C, "R7", "busy length", 64'(bcnt), 64'(BUSY_C));
          chk(!hold_bad, "R9", "line changed while mdc high", 64'(hold_bad), '0);
        end
        nrise = 0; bcnt = 0; hold_bad = 1'b0;
        min_hi = 1 << 30; max_hi = 0; min_lo = 1 << 30; mdio_i = 1'b1;
      end
      if (rd_valid) begin
        if (exp_rd.size() == 0) chk(1'b0, "R6", "unexpected read strobe", 64'(rd_data), '0);
        else begin
          logic [15:0] er;
          er = exp_rd.pop_front();
          chk(rd_data == er && !busy, "R6", "read word", 64'(rd_data), 64'(er));
        end
      end
    end
    prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe; prev_busy = busy;
  end

  // Driver
  task automatic issue(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] wd, input logic [15:0] resp);
    logic [63:0] eb;
    while (!cmd_ready) @(negedge clk);
    cur_rd = rd; phy_resp = resp;
    eb = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
          (rd ? 2'b11 : 2'b10), (rd ? resp : wd)};
    exp_bits.push_back(eb);
    exp_oe.push_back(rd ? 64'hFFFF_FFFF_FFFC_0000 : '1);
    if (rd) exp_rd.push_back(resp);
    cmd_read = rd; cmd_phy = phy; cmd_reg = rg; cmd_wdata = wd; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!mdc && !busy && !mdio_oe && !rd_valid && cmd_ready, "R1", "reset outputs",
        {mdc, busy, mdio_oe, rd_valid, cmd_ready}, 64'h1);

    issue(1'b0, 5'd0, 5'd0, 16'hA5C3, '0);   wait_idle();   // R4 low addresses
    issue(1'b0, 5'd31, 5'd31, 16'hFFFF, '0); wait_idle();   // R4 high addresses
    issue(1'b1, 5'd5, 5'd2, '0, 16'h1234);   wait_idle();   // R5 R6
    issue(1'b1, 5'd31, 5'd17, '0, 16'h8001); wait_idle();   // R6 edge bits
    issue(1'b0, 5'd16, 5'd1, 16'h0000, '0);                 // R7 back-to-back

    // R8: command pulses during a frame are ignored
    wait_idle();
    issue(1'b1, 5'd10, 5'd21, '0, 16'h6BD9);
    repeat (150) @(negedge clk);
    chk(!cmd_ready, "R8", "ready while busy", 64'(cmd_ready), '0);
    cmd_read = 1'b0; cmd_phy = 5'd3; cmd_reg = 5'd4; cmd_wdata = 16'hDEAD;
    cmd_valid = 1'b1;
    repeat (5) @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
    repeat (60) @(negedge clk);
    chk(!busy && nrise == 0 && !mdc, "R8", "no frame after ignored command",
        64'(nrise), '0);

    repeat (10) @(negedge clk);
    chk(exp_bits.size() == 0 && exp_rd.size() == 0, "R7", "pending expectations",
        64'(exp_bits.size() + exp_rd.size()), '0);
    chk(fr_count == 6, "R8", "frame count", 64'(fr_count), 64'd6);
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_total++; n_bad++;
    $display("FAIL R7 watchdog expired: actual=%0d expected=%0d", fr_count, 6);
    summary();
    $finish;
  end
endmodule